// File: doc/BRIEF.md
# DRAM Cycle-Type Decoder

This block models the control side of an asynchronous DRAM, with the storage array left out. It samples the row strobe, column strobe, write enable and the multiplexed address pins on a system clock. It passes them through a synchronizer and finds strobe edges on the synchronized copies. From the order of those edges it classifies every memory cycle. The classes are read, early write, read-write (late write), row-only refresh, column-before-row refresh, hidden refresh and test-mode entry.

The block latches the row address on the row-strobe fall and the column address on each column-strobe fall. It also keeps a 10-bit refresh row counter, a test-mode flag, an early-write indicator and the output-enable for the data pin. Every classified cycle is reported as a one-clock pulse together with its class code. A surrounding memory model, or a bench, can then follow the cycle sequence and drive or release the data pin from `q_oe`.

Top module: `dram_cycle_decoder`

## Requirements
- R1: `cyc_valid` pulses for exactly one clock per classified cycle, with `cyc_cls` coded 1 read, 2 early write, 3 read-write, 4 row-only refresh, 5 column-before-row refresh, 6 hidden refresh, 7 test-mode entry; with no pulse `cyc_cls` is 0. After reset `cyc_valid`, `q_oe`, `early_wr` and `test_mode` are 0.
- R2: If the column strobe is already low when the row strobe falls, the cycle is a column-before-row refresh: class 5 with write enable high, class 7 with it low. `rfsh_row` takes the refresh counter value, and the address pins are ignored (`row_addr` keeps its value).
- R3: The refresh counter is 10 bits and is 0 after reset. Each cycle of class 5, 6 or 7 uses its current value and advances it by one, and 1023 wraps to 0.
- R4: `test_mode` is set by a class 7 cycle and cleared by a class 5 or class 4 cycle. Accesses and hidden refreshes leave it unchanged.
- R5: A row-strobe low period that starts with the column strobe high and ends with no column-strobe fall is reported as class 4 at the row-strobe rise. `rfsh_row` is then the row latched from address bits 0..9, and bit 10 is ignored.
- R6: A column-strobe fall while the row strobe is low in an access cycle latches `col_addr`, with `row_addr` latched at the row-strobe fall. With write enable already low this is class 2: one `wr_strobe` pulse, `early_wr`=1 and `q_oe` stays 0. Otherwise it is class 1 with `early_wr`=0 and `q_oe`=1.
- R7: A write-enable fall while the column strobe is low in a read access is class 3, with one `wr_strobe` pulse and `q_oe` held at 1. Only the first such fall in an access counts.
- R8: `q_oe` is 0 in every clock after the synchronized column strobe is high.
- R9: After an access, if the row strobe goes high and then low again while the column strobe stays low, the cycle is class 6. The refresh counter advances and `q_oe` keeps its value.
- R10: Toggling the column strobe while the row strobe stays low gives further accesses in the same row. Each one is classified on its own, and `row_addr` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | ADDR_W (11) | Multiplexed row/column address |
| cyc_valid | output | 1 | One-clock pulse per classified cycle |
| cyc_cls | output | 3 | Class code of the pulsed cycle |
| row_addr | output | ADDR_W | Latched row address |
| col_addr | output | ADDR_W | Latched column address |
| rfsh_row | output | REF_W (10) | Row refreshed by the last refresh cycle |
| test_mode | output | 1 | Test-mode flag |
| wr_strobe | output | 1 | One-clock write pulse for the array |
| q_oe | output | 1 | Data-pin output enable |
| early_wr | output | 1 | 1 after an early write, 0 after a column-first access |

## Verification
Hidden refresh is the case where refresh and the data path overlap. In the same clock that the refresh counter steps and the class 6 pulse is issued, the output enable of the still-open read must stay asserted. The bench provokes this by holding the column strobe low after a read and pulsing the row strobe high and low again. It then checks, away from the clock edge, the pulse class, the refreshed row, the counter step and that `q_oe` remains 1, and finally that `q_oe` drops once the column strobe rises.

// File: rtl/dcd_pkg.sv
`timescale 1ns/1ps
package dcd_pkg;

  typedef enum logic [2:0] {
    CY_NONE   = 3'd0,
    CY_READ   = 3'd1,
    CY_EWRITE = 3'd2,
    CY_RDWR   = 3'd3,
    CY_RONLY  = 3'd4,
    CY_CBR    = 3'd5,
    CY_HIDDEN = 3'd6,
    CY_WCBR   = 3'd7
  } cyc_e;

  // Classes that take their row from the internal counter.
  function automatic logic f_uses_counter(input cyc_e c);
    return (c == CY_CBR) || (c == CY_HIDDEN) || (c == CY_WCBR);
  endfunction

  // Classes that issue a write to the array.
  function automatic logic f_is_write(input cyc_e c);
    return (c == CY_EWRITE) || (c == CY_RDWR);
  endfunction

endpackage

// File: rtl/dcd_sync.sv
`timescale 1ns/1ps
module dcd_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= d;
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dcd_refresh_ctr.sv
`timescale 1ns/1ps
module dcd_refresh_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] cnt
);
  function automatic logic [W-1:0] f_row_next(input logic [W-1:0] cur);
    return cur + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= f_row_next(cnt);
  end
endmodule

// File: rtl/dcd_classifier.sv
`timescale 1ns/1ps
module dcd_classifier
  import dcd_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int REF_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_s,
  input  logic              cas_s,
  input  logic              we_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [REF_W-1:0]  ref_cnt,
  output logic              ref_step,
  output logic              cyc_valid,
  output cyc_e              cyc_cls,
  output logic [ADDR_W-1:0] row_addr,
  output logic [ADDR_W-1:0] col_addr,
  output logic [REF_W-1:0]  rfsh_row,
  output logic              test_mode,
  output logic              wr_strobe,
  output logic              q_oe,
  output logic              early_wr
);
  // Previous samples of the synchronized strobes.
  logic ras_p, cas_p, we_p;

  // Cycle-tracking state.
  logic row_open;    // row strobe low in an access cycle
  logic col_seen;    // an access happened in this row period
  logic acc_hold;    // an access is open and the column strobe is still low
  logic rd_pending;  // open read access that may still turn into read-write

  // Edge events.
  logic ras_fall, ras_rise, cas_fall, we_fall;
  logic cbr_start, row_start, row_live;
  logic access, hidden, plain_cbr, ror_done, rmw;
  cyc_e cls_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_p <= 1'b1;
      cas_p <= 1'b1;
      we_p  <= 1'b1;
    end else begin
      ras_p <= ras_s;
      cas_p <= cas_s;
      we_p  <= we_s;
    end
  end

  assign ras_fall  = ras_p & ~ras_s;
  assign ras_rise  = ~ras_p & ras_s;
  assign cas_fall  = cas_p & ~cas_s;
  assign we_fall   = we_p & ~we_s;

  // Column strobe already low before the row strobe fell: refresh by counter.
  assign cbr_start = ras_fall & ~cas_p;
  assign row_start = ras_fall & cas_p;
  assign row_live  = row_open | row_start;

  assign access    = cas_fall & ~ras_s & row_live;
  assign hidden    = cbr_start & acc_hold;
  assign plain_cbr = cbr_start & ~acc_hold;
  assign ror_done  = ras_rise & row_open & ~col_seen;
  assign rmw       = we_fall & ~cas_s & ~ras_s & rd_pending & ~access;

  assign ref_step  = cbr_start;

  always_comb begin
    cls_n = CY_NONE;
    if (hidden)         cls_n = CY_HIDDEN;
    else if (plain_cbr) cls_n = we_s ? CY_CBR : CY_WCBR;
    else if (ror_done)  cls_n = CY_RONLY;
    else if (access)    cls_n = we_s ? CY_READ : CY_EWRITE;
    else if (rmw)       cls_n = CY_RDWR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_open   <= 1'b0;
      col_seen   <= 1'b0;
      acc_hold   <= 1'b0;
      rd_pending <= 1'b0;
    end else begin
      if (ras_s)          row_open <= 1'b0;
      else if (row_start) row_open <= 1'b1;

      if (ras_s)       col_seen <= 1'b0;
      else if (access) col_seen <= 1'b1;

      if (cas_s)       acc_hold <= 1'b0;
      else if (access) acc_hold <= 1'b1;

      if (cas_s || ras_s)      rd_pending <= 1'b0;
      else if (access)         rd_pending <= we_s;
      else if (rmw)            rd_pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_addr  <= '0;
      col_addr  <= '0;
      rfsh_row  <= '0;
      test_mode <= 1'b0;
      q_oe      <= 1'b0;
      early_wr  <= 1'b0;
      wr_strobe <= 1'b0;
      cyc_valid <= 1'b0;
      cyc_cls   <= CY_NONE;
    end else begin
      if (row_start) row_addr <= addr_s;
      if (access)    col_addr <= addr_s;

      if (cbr_start)     rfsh_row <= ref_cnt;
      else if (ror_done) rfsh_row <= row_addr[REF_W-1:0];

      if (plain_cbr)     test_mode <= ~we_s;
      else if (ror_done) test_mode <= 1'b0;

      if (cas_s)       q_oe <= 1'b0;
      else if (access) q_oe <= we_s;

      if (access) early_wr <= ~we_s;

      wr_strobe <= (access & ~we_s) | rmw;
      cyc_valid <= (cls_n != CY_NONE);
      cyc_cls   <= cls_n;
    end
  end
endmodule

// File: rtl/dram_cycle_decoder.sv
`timescale 1ns/1ps
module dram_cycle_decoder #(
  parameter int ADDR_W      = 11,
  parameter int REF_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              cyc_valid,
  output logic [2:0]        cyc_cls,
  output logic [ADDR_W-1:0] row_addr,
  output logic [ADDR_W-1:0] col_addr,
  output logic [REF_W-1:0]  rfsh_row,
  output logic              test_mode,
  output logic              wr_strobe,
  output logic              q_oe,
  output logic              early_wr
);
  localparam int              BUS_W    = ADDR_W + 3;
  localparam logic [BUS_W-1:0] BUS_IDLE = {3'b111, {ADDR_W{1'b0}}};

  logic [BUS_W-1:0]  bus_s;
  logic              ras_s, cas_s, we_s;
  logic [ADDR_W-1:0] addr_s;
  logic [REF_W-1:0]  ref_cnt;
  logic              ref_step;
  dcd_pkg::cyc_e     cls_e;

  dcd_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ras_n, cas_n, we_n, addr}),
    .q     (bus_s)
  );

  assign ras_s  = bus_s[BUS_W-1];
  assign cas_s  = bus_s[BUS_W-2];
  assign we_s   = bus_s[BUS_W-3];
  assign addr_s = bus_s[ADDR_W-1:0];

  dcd_refresh_ctr #(.W(REF_W)) i_rctr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (ref_step),
    .cnt   (ref_cnt)
  );

  dcd_classifier #(.ADDR_W(ADDR_W), .REF_W(REF_W)) i_cls (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_s     (ras_s),
    .cas_s     (cas_s),
    .we_s      (we_s),
    .addr_s    (addr_s),
    .ref_cnt   (ref_cnt),
    .ref_step  (ref_step),
    .cyc_valid (cyc_valid),
    .cyc_cls   (cls_e),
    .row_addr  (row_addr),
    .col_addr  (col_addr),
    .rfsh_row  (rfsh_row),
    .test_mode (test_mode),
    .wr_strobe (wr_strobe),
    .q_oe      (q_oe),
    .early_wr  (early_wr)
  );

  assign cyc_cls = cls_e;
endmodule

// File: rtl/dcd_checker.sv
`timescale 1ns/1ps
module dcd_checker
  import dcd_pkg::*;
#(
  parameter int REF_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cas_s,
  input logic             ref_step,
  input logic [REF_W-1:0] ref_cnt,
  input logic             cyc_valid,
  input logic [2:0]       cyc_cls,
  input logic             wr_strobe,
  input logic             q_oe,
  input logic             test_mode,
  input logic             early_wr
);
  function automatic logic [REF_W-1:0] f_after(input logic [REF_W-1:0] v);
    return v + 1'b1;
  endfunction

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |-> cyc_cls == CY_NONE); // R1
  AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ref_step |=> ref_cnt == f_after($past(ref_cnt))); // R3
  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_step |=> $stable(ref_cnt)); // R3
  AST_REF_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    ref_step |=> cyc_valid && f_uses_counter(cyc_e'(cyc_cls))); // R2
  AST_TM_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && cyc_cls == CY_WCBR |-> test_mode); // R4
  AST_TM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && (cyc_cls == CY_CBR || cyc_cls == CY_RONLY) |-> !test_mode); // R4
  AST_EW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && cyc_cls == CY_EWRITE |-> !q_oe && early_wr); // R6
  AST_RD_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && (cyc_cls == CY_READ || cyc_cls == CY_RDWR) |-> q_oe); // R7
  AST_WR_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> cyc_valid && f_is_write(cyc_e'(cyc_cls))); // R7
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cas_s |=> !q_oe); // R8
endmodule

bind dram_cycle_decoder dcd_checker #(.REF_W(REF_W)) i_dcd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cas_s     (cas_s),
  .ref_step  (ref_step),
  .ref_cnt   (ref_cnt),
  .cyc_valid (cyc_valid),
  .cyc_cls   (cyc_cls),
  .wr_strobe (wr_strobe),
  .q_oe      (q_oe),
  .test_mode (test_mode),
  .early_wr  (early_wr)
);

// File: tb/test_dram_cycle_decoder.sv
`timescale 1ns/1ps
module test_dram_cycle_decoder;
  localparam int G = 4;
  localparam logic [2:0] OP_RD = 3'd0, OP_EW = 3'd1, OP_RMW = 3'd2,
                         OP_ROR = 3'd3, OP_CBR = 3'd4, OP_WCBR = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [10:0] row;
    logic [10:0] col;
    logic [2:0]  cls;
    logic [1:0]  np;
    logic [1:0]  nwr;
    logic        oe;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{OP_RD,   11'h123, 11'h045, 3'd1, 2'd1, 2'd0, 1'b1},
    '{OP_EW,   11'h7FF, 11'h3A0, 3'd2, 2'd1, 2'd1, 1'b0},
    '{OP_RMW,  11'h400, 11'h7FF, 3'd3, 2'd2, 2'd1, 1'b1},
    '{OP_WCBR, 11'h000, 11'h000, 3'd7, 2'd1, 2'd0, 1'b0},
    '{OP_RD,   11'h011, 11'h022, 3'd1, 2'd1, 2'd0, 1'b1},
    '{OP_ROR,  11'h5A5, 11'h000, 3'd4, 2'd1, 2'd0, 1'b0},
    '{OP_WCBR, 11'h000, 11'h000, 3'd7, 2'd1, 2'd0, 1'b0},
    '{OP_CBR,  11'h000, 11'h000, 3'd5, 2'd1, 2'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [10:0] addr = '0;
  logic        cyc_valid, test_mode, wr_strobe, q_oe, early_wr;
  logic [2:0]  cyc_cls;
  logic [10:0] row_addr, col_addr;
  logic [9:0]  rfsh_row;

  int nchk = 0, nerr = 0;
  int npulse = 0, nwr = 0;
  logic [2:0] last_cls = '0;
  logic [9:0] last_rfsh = '0;
  int  cnt = 0;
  logic tm = 1'b0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  dram_cycle_decoder i_dram_cycle_decoder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .cyc_valid(cyc_valid), .cyc_cls(cyc_cls),
    .row_addr(row_addr), .col_addr(col_addr), .rfsh_row(rfsh_row),
    .test_mode(test_mode), .wr_strobe(wr_strobe), .q_oe(q_oe),
    .early_wr(early_wr)
  );

  always @(negedge clk) begin
    if (rst_n && cyc_valid) begin
      npulse   <= npulse + 1;
      last_cls <= cyc_cls;
      last_rfsh <= rfsh_row;
      if (wr_strobe) nwr <= nwr + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  // One bus cycle of the given kind; oe_mid is q_oe while the column strobe is low.
  task automatic do_op(input logic [2:0] op, input logic [10:0] row, input logic [10:0] col,
                       output logic oe_mid, output logic oe_end);
    oe_mid = 1'b0;
    if (op == OP_CBR || op == OP_WCBR) begin
      addr = 11'h7FF;
      cas_n = 1'b0; tick(G);
      if (op == OP_WCBR) we_n = 1'b0;
      tick(2);
      ras_n = 1'b0; tick(G);
      ras_n = 1'b1; tick(2);
      cas_n = 1'b1; we_n = 1'b1;
    end else if (op == OP_ROR) begin
      addr = row; tick(2);
      ras_n = 1'b0; tick(G);
      addr = ~row; tick(G);
      ras_n = 1'b1;
    end else begin
      addr = row; tick(2);
      ras_n = 1'b0; tick(G);
      addr = col;
      if (op == OP_EW) we_n = 1'b0;
      tick(2);
      cas_n = 1'b0; tick(G);
      oe_mid = q_oe;
      if (op == OP_RMW) begin
        we_n = 1'b0; tick(G);
        oe_mid = q_oe;
      end
      cas_n = 1'b1; tick(G);
      ras_n = 1'b1; we_n = 1'b1;
    end
    tick(G);
    oe_end = q_oe;
  endtask

  task automatic model_refresh(input logic [2:0] op);
    if (op == OP_CBR || op == OP_WCBR) cnt = (cnt + 1) % 1024;
    if (op == OP_WCBR) tm = 1'b1;
    if (op == OP_CBR || op == OP_ROR) tm = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    nerr++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    logic oe_mid, oe_end;
    int p0, w0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    // Reset state
    chk("R1", "cyc_valid after reset", cyc_valid, 0);
    chk("R1", "q_oe after reset", q_oe, 0);
    chk("R4", "test_mode after reset", test_mode, 0);
    chk("R3", "rfsh_row after reset", rfsh_row, 0);
    chk("R1", "early_wr after reset", early_wr, 0);

    // Vector table
    for (int i = 0; i < 8; i++) begin
      p0 = npulse; w0 = nwr;
      do_op(VEC[i].op, VEC[i].row, VEC[i].col, oe_mid, oe_end);
      chk("R1", $sformatf("v%0d pulse count", i), npulse - p0, VEC[i].np);
      chk("R1", $sformatf("v%0d class", i), last_cls, VEC[i].cls);
      chk("R7", $sformatf("v%0d write pulses", i), nwr - w0, VEC[i].nwr);
      chk("R8", $sformatf("v%0d q_oe after cas high", i), oe_end, 0);
      if (VEC[i].op <= OP_RMW) begin
        chk("R6", $sformatf("v%0d row_addr", i), row_addr, VEC[i].row);
        chk("R6", $sformatf("v%0d col_addr", i), col_addr, VEC[i].col);
        chk("R6", $sformatf("v%0d q_oe in access", i), oe_mid, VEC[i].oe);
        chk("R6", $sformatf("v%0d early_wr", i), early_wr, VEC[i].op == OP_EW);
      end else if (VEC[i].op == OP_ROR) begin
        chk("R5", $sformatf("v%0d refreshed row", i), last_rfsh, VEC[i].row[9:0]);
      end else begin
        chk("R2", $sformatf("v%0d refreshed row", i), last_rfsh, cnt);
      end
      model_refresh(VEC[i].op);
      chk("R4", $sformatf("v%0d test_mode", i), test_mode, tm);
    end

    // Hidden refresh during a held read, with test mode set beforehand
    do_op(OP_WCBR, '0, '0, oe_mid, oe_end);
    model_refresh(OP_WCBR);
    addr = 11'h0F0; tick(2);
    ras_n = 1'b0; tick(G);
    addr = 11'h00F; tick(2);
    cas_n = 1'b0; tick(G);
    p0 = npulse;
    ras_n = 1'b1; tick(G);
    chk("R9", "q_oe with row strobe high", q_oe, 1);
    ras_n = 1'b0; tick(G);
    chk("R9", "hidden pulse count", npulse - p0, 1);
    chk("R9", "hidden class", last_cls, 6);
    chk("R3", "hidden refreshed row", last_rfsh, cnt);
    chk("R9", "q_oe held through hidden refresh", q_oe, 1);
    chk("R4", "test_mode kept by hidden refresh", test_mode, 1);
    cnt = (cnt + 1) % 1024;
    ras_n = 1'b1; tick(2);
    cas_n = 1'b1; tick(G);
    chk("R8", "q_oe released after hidden", q_oe, 0);
    chk("R9", "no extra pulse after hidden", npulse - p0, 1);

    // Page mode: read, early write, read in one row
    p0 = npulse;
    addr = 11'h2AA; tick(2);
    ras_n = 1'b0; tick(G);
    addr = 11'h001; tick(2);
    cas_n = 1'b0; tick(G);
    chk("R10", "page read 1 class", last_cls, 1);
    cas_n = 1'b1; addr = 11'h002; we_n = 1'b0; tick(G);
    cas_n = 1'b0; tick(G);
    chk("R10", "page early write class", last_cls, 2);
    chk("R6", "early_wr after page write", early_wr, 1);
    chk("R6", "q_oe off in page write", q_oe, 0);
    cas_n = 1'b1; we_n = 1'b1; addr = 11'h003; tick(G);
    cas_n = 1'b0; tick(G);
    chk("R10", "page read 2 class", last_cls, 1);
    chk("R6", "early_wr after column-first access", early_wr, 0);
    chk("R10", "page pulse count", npulse - p0, 3);
    chk("R10", "row kept in page", row_addr, 11'h2AA);
    chk("R10", "last column", col_addr, 11'h003);
    cas_n = 1'b1; tick(2);
    ras_n = 1'b1; tick(G);
    chk("R5", "no row-only refresh after accesses", npulse - p0, 3);

    // Column-before-row ignores address pins; test mode cleared
    do_op(OP_CBR, '0, '0, oe_mid, oe_end);
    chk("R2", "row_addr untouched by refresh", row_addr, 11'h2AA);
    chk("R2", "refreshed row from counter", last_rfsh, cnt);
    model_refresh(OP_CBR);
    chk("R4", "test_mode cleared", test_mode, 0);

    // Counter wrap
    while (cnt != 1023) begin
      do_op(OP_CBR, '0, '0, oe_mid, oe_end);
      model_refresh(OP_CBR);
    end
    do_op(OP_CBR, '0, '0, oe_mid, oe_end);
    chk("R3", "refresh row 1023", last_rfsh, 1023);
    model_refresh(OP_CBR);
    do_op(OP_CBR, '0, '0, oe_mid, oe_end);
    chk("R3", "refresh row wraps to 0", last_rfsh, 0);
    tick(4);
    finish_run();
  end
endmodule